// File: doc/BRIEF.md
# Windowed Performance Event Counters

This block holds a small bank of event counters that accumulate selected per-cycle processor events, but only while a measurement window is open. Each counter picks its own event through a small select code, so several distinct quantities (elapsed cycles, branches, retired instructions, cache misses and so on) can be measured over the same window at once.

The window is chosen by a mode input. In the two paired modes, a match pulse from one comparator channel opens the window and a match pulse from the other channel closes it. In the whole-run mode, counting follows the run status, from the start of program execution until a break. A window that closes and later reopens keeps adding to the totals already held. A single clear pulse wipes every total and overflow flag. Results are read one counter at a time through an index-addressed read port. A counter that runs past its maximum raises a sticky overflow flag in place of a usable value.

Top module: `perf_window_counters`

## Requirements
- R1: After reset every counter reads zero with its overflow flag low, and the paired-mode window is closed.
- R2: In whole-run mode (mode code 0, and the reserved code 3, which behaves the same), a counter adds one for every cycle in which `run_i` is high and its selected event is present. While `run_i` is low the totals hold.
- R3: In mode code 1, a `ch2_hit_i` pulse opens the window from the following cycle. A `ch1_hit_i` pulse while the window is open still counts the event in its own cycle and closes the window from the next cycle on.
- R4: In mode code 2 the roles are swapped: `ch1_hit_i` opens the window and `ch2_hit_i` closes it, with the same cycle timing as R3.
- R5: In the paired modes, counting requires both an open window and `run_i` high. Reopening the window after it has closed resumes counting from the previous totals.
- R6: While the window is closed, an end pulse that arrives together with a start pulse is ignored and the window opens. While the window is open, a start pulse has no effect.
- R7: Select code 0 disables a counter. Code 1 counts every cycle. Code k, for k from 2 to NUM_EVT+1, counts `evt_i[k-2]`. Any larger code disables the counter.
- R8: Counter n takes its select code from `sel_i[n*SEL_W +: SEL_W]`, and each counter accumulates independently of the others.
- R9: An increment of a counter already at its all-ones value sets that counter's overflow flag. The flag stays set until a clear, the count holds at all-ones, and the port reads all-ones with `rd_ovf_o` high.
- R10: A `clear_i` cycle zeroes all counts and overflow flags and closes the window, taking precedence over any event in the same cycle.
- R11: `rd_data_o` and `rd_ovf_o` combinationally show the counter addressed by `rd_idx_i`. An index with no counter behind it reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | High while the program runs, low during a break |
| win_mode_i | input | 2 | Window mode: 0 whole-run, 1 ch2 opens and ch1 closes, 2 ch1 opens and ch2 closes, 3 as 0 |
| ch1_hit_i | input | 1 | Match pulse from comparator channel 1 |
| ch2_hit_i | input | 1 | Match pulse from comparator channel 2 |
| evt_i | input | NUM_EVT | Per-cycle event strobes |
| sel_i | input | NUM_CTR*SEL_W | Packed event select code per counter |
| clear_i | input | 1 | Clears all totals, flags and the window |
| rd_idx_i | input | IDX_W | Counter index for the read port |
| rd_data_o | output | CNT_W | Count of the addressed counter |
| rd_ovf_o | output | 1 | Overflow flag of the addressed counter |

## Verification
The counters are exercised in whole-run mode with run/break toggling, which separates run gating from window gating. Directed pulse sequences in both paired modes check the one-cycle opening delay, counting in the closing cycle, accumulation across reopening, and the simultaneous start and end cases. A mix of codes is tried (disabled, cycles, each strobe and an out-of-range code) to show that every select lands on its own event. A long run of counted cycles drives a counter into overflow and then clears it. A seeded random phase then mixes modes, pulses, breaks and clears against an independent model of the totals.

// File: rtl/perf_win_pkg.sv
package perf_win_pkg;

   typedef enum logic [1:0] {
      WIN_WHOLE_RUN = 2'd0,
      WIN_C2_TO_C1  = 2'd1,
      WIN_C1_TO_C2  = 2'd2,
      WIN_RESERVED  = 2'd3
   } win_mode_e;

   function automatic logic mode_is_paired(input logic [1:0] m);
      return (m == WIN_C2_TO_C1) || (m == WIN_C1_TO_C2);
   endfunction

endpackage

// File: rtl/perf_win_gate.sv
module perf_win_gate
   import perf_win_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_i,
   input  logic       run_i,
   input  logic [1:0] mode_i,
   input  logic       ch1_hit_i,
   input  logic       ch2_hit_i,
   output logic       open_o,
   output logic       count_en_o
);

   logic paired;
   logic start_ev;
   logic stop_ev;
   logic open_q;

   always_comb begin
      paired   = mode_is_paired(mode_i);
      start_ev = 1'b0;
      stop_ev  = 1'b0;
      unique case (mode_i)
         WIN_C2_TO_C1: begin start_ev = ch2_hit_i; stop_ev = ch1_hit_i; end
         WIN_C1_TO_C2: begin start_ev = ch1_hit_i; stop_ev = ch2_hit_i; end
         default:      begin start_ev = 1'b0;      stop_ev = 1'b0;      end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (clear_i || !paired) begin
         open_q <= 1'b0;
      end else if (!open_q && start_ev) begin
         open_q <= 1'b1;
      end else if (open_q && stop_ev) begin
         open_q <= 1'b0;
      end
   end

   assign open_o     = open_q;
   assign count_en_o = paired ? (open_q && run_i) : run_i;

endmodule

// File: rtl/perf_evt_mux.sv
module perf_evt_mux #(
   parameter int NUM_EVT = 8,
   parameter int SEL_W   = 5
) (
   input  logic [SEL_W-1:0]   code_i,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               hit_o
);

   localparam int SRC_N = NUM_EVT + 2;

   logic [SRC_N-1:0] src;

   assign src = {evt_i, 1'b1, 1'b0};

   always_comb begin
      hit_o = 1'b0;
      for (int k = 0; k < SRC_N; k++) begin
         if (code_i == SEL_W'(k)) hit_o = src[k];
      end
   end

endmodule

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clear_i) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (inc_i && !ovf_q) begin
         if (cnt_q == CNT_MAX) begin
            ovf_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

endmodule

// File: rtl/perf_window_counters.sv
module perf_window_counters #(
   parameter int NUM_CTR = 4,
   parameter int NUM_EVT = 8,
   parameter int SEL_W   = 5,
   parameter int CNT_W   = 32,
   localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_i,
   input  logic [1:0]               win_mode_i,
   input  logic                     ch1_hit_i,
   input  logic                     ch2_hit_i,
   input  logic [NUM_EVT-1:0]       evt_i,
   input  logic [NUM_CTR*SEL_W-1:0] sel_i,
   input  logic                     clear_i,
   input  logic [IDX_W-1:0]         rd_idx_i,
   output logic [CNT_W-1:0]         rd_data_o,
   output logic                     rd_ovf_o
);

   if (NUM_CTR < 1 || NUM_CTR > 16) begin : g_bad_ctr
      $fatal(1, "NUM_CTR out of range");
   end
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_w
      $fatal(1, "CNT_W out of range");
   end
   if (NUM_EVT < 1 || (NUM_EVT + 2) > (1 << SEL_W)) begin : g_bad_evt
      $fatal(1, "SEL_W too narrow for NUM_EVT");
   end

   logic                     win_open;
   logic                     count_en;
   logic [NUM_CTR*CNT_W-1:0] cnt_flat;
   logic [NUM_CTR-1:0]       ovf_vec;
   logic [NUM_CTR-1:0]       hit_vec;

   perf_win_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (clear_i),
      .run_i      (run_i),
      .mode_i     (win_mode_i),
      .ch1_hit_i  (ch1_hit_i),
      .ch2_hit_i  (ch2_hit_i),
      .open_o     (win_open),
      .count_en_o (count_en)
   );

   for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
      perf_evt_mux #(
         .NUM_EVT (NUM_EVT),
         .SEL_W   (SEL_W)
      ) u_mux (
         .code_i (sel_i[n*SEL_W +: SEL_W]),
         .evt_i  (evt_i),
         .hit_o  (hit_vec[n])
      );

      perf_ctr_slice #(
         .CNT_W (CNT_W)
      ) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear_i (clear_i),
         .inc_i   (hit_vec[n] && count_en),
         .cnt_o   (cnt_flat[n*CNT_W +: CNT_W]),
         .ovf_o   (ovf_vec[n])
      );
   end

   always_comb begin
      rd_data_o = '0;
      rd_ovf_o  = 1'b0;
      for (int n = 0; n < NUM_CTR; n++) begin
         if (rd_idx_i == IDX_W'(n)) begin
            rd_ovf_o  = ovf_vec[n];
            rd_data_o = ovf_vec[n] ? {CNT_W{1'b1}} : cnt_flat[n*CNT_W +: CNT_W];
         end
      end
   end

endmodule

// File: rtl/perf_window_counters_chk.sv
module perf_window_counters_chk
   import perf_win_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CNT_W   = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     run_i,
   input logic [1:0]               win_mode_i,
   input logic                     ch1_hit_i,
   input logic                     ch2_hit_i,
   input logic                     clear_i,
   input logic                     win_open,
   input logic [NUM_CTR*CNT_W-1:0] cnt_flat,
   input logic [NUM_CTR-1:0]       ovf_vec,
   input logic [CNT_W-1:0]         rd_data_o,
   input logic                     rd_ovf_o
);

   // R10: a clear leaves every total, flag and the window at zero
   a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_flat == '0 && ovf_vec == '0 && !win_open));

   // R2 / R5: nothing moves during a break
   a_r2_hold_in_break: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clear_i) |=> $stable(cnt_flat));

   // R3: ch2 opens the window one cycle later
   a_r3_open_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (win_mode_i == WIN_C2_TO_C1 && !win_open && ch2_hit_i && !clear_i) |=> win_open);

   // R3: ch1 closes the open window
   a_r3_close_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (win_mode_i == WIN_C2_TO_C1 && win_open && ch1_hit_i && !clear_i) |=> !win_open);

   // R4: ch1 opens the window in the swapped mode
   a_r4_open_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (win_mode_i == WIN_C1_TO_C2 && !win_open && ch1_hit_i && !clear_i) |=> win_open);

   // R4: ch2 closes it
   a_r4_close_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (win_mode_i == WIN_C1_TO_C2 && win_open && ch2_hit_i && !clear_i) |=> !win_open);

   // R2: no window state exists in whole-run mode
   a_r2_no_window: assert property (@(posedge clk) disable iff (!rst_n)
      (win_mode_i == WIN_WHOLE_RUN) |=> !win_open);

   // R11: an overflowed read shows all ones
   a_r11_read_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ovf_o |-> (rd_data_o == {CNT_W{1'b1}}));

   for (genvar n = 0; n < NUM_CTR; n++) begin : g_ovf
      // R9: the flag is sticky until a clear
      a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf_vec[n] && !clear_i) |=> ovf_vec[n]);
      // R9: an overflowed counter sits at its maximum
      a_r9_ovf_saturated: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_vec[n] |-> (cnt_flat[n*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
   end

endmodule

bind perf_window_counters perf_window_counters_chk #(
   .NUM_CTR (NUM_CTR),
   .CNT_W   (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_i      (run_i),
   .win_mode_i (win_mode_i),
   .ch1_hit_i  (ch1_hit_i),
   .ch2_hit_i  (ch2_hit_i),
   .clear_i    (clear_i),
   .win_open   (win_open),
   .cnt_flat   (cnt_flat),
   .ovf_vec    (ovf_vec),
   .rd_data_o  (rd_data_o),
   .rd_ovf_o   (rd_ovf_o)
);

// File: tb/perf_window_counters_bench.sv
`timescale 1ns/1ps
module perf_window_counters_bench;

   localparam int NUM_CTR = 4;
   localparam int NUM_EVT = 8;
   localparam int SEL_W   = 5;
   localparam int CNT_W   = 10;
   localparam int IDX_W   = 2;
   localparam int MAXV    = (1 << CNT_W) - 1;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     run = 1'b0;
   logic [1:0]               mode = 2'd0;
   logic                     ch1 = 1'b0;
   logic                     ch2 = 1'b0;
   logic [NUM_EVT-1:0]       evt = '0;
   logic [NUM_CTR*SEL_W-1:0] sel = '0;
   logic                     clr = 1'b0;
   logic [IDX_W-1:0]         rd_idx = '0;
   logic [CNT_W-1:0]         rd_data;
   logic                     rd_ovf;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;
   int  exp_cnt [NUM_CTR];
   bit  exp_ovf [NUM_CTR];
   bit  exp_open = 1'b0;

   always #2.5 clk = ~clk;

   perf_window_counters #(
      .NUM_CTR (NUM_CTR),
      .NUM_EVT (NUM_EVT),
      .SEL_W   (SEL_W),
      .CNT_W   (CNT_W)
   ) u_perf_window_counters (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .win_mode_i (mode),
      .ch1_hit_i  (ch1),
      .ch2_hit_i  (ch2),
      .evt_i      (evt),
      .sel_i      (sel),
      .clear_i    (clr),
      .rd_idx_i   (rd_idx),
      .rd_data_o  (rd_data),
      .rd_ovf_o   (rd_ovf)
   );

   // R7: code 0 off, 1 cycles, 2..NUM_EVT+1 strobes, above off
   function automatic bit ev_hit(input int code, input logic [NUM_EVT-1:0] e);
      if (code == 0) return 1'b0;
      if (code == 1) return 1'b1;
      if (code <= NUM_EVT + 1) return e[code-2];
      return 1'b0;
   endfunction

   function automatic bit is_paired(input logic [1:0] m);
      return (m == 2'd1) || (m == 2'd2);
   endfunction

   task automatic model_edge();
      bit gate;
      bit st;
      bit sp;
      gate = is_paired(mode) ? (exp_open && run) : run;
      st = (mode == 2'd1) ? ch2 : (mode == 2'd2) ? ch1 : 1'b0;
      sp = (mode == 2'd1) ? ch1 : (mode == 2'd2) ? ch2 : 1'b0;
      if (clr) begin
         for (int n = 0; n < NUM_CTR; n++) begin exp_cnt[n] = 0; exp_ovf[n] = 1'b0; end
         exp_open = 1'b0;
      end else begin
         for (int n = 0; n < NUM_CTR; n++) begin
            if (!exp_ovf[n] && gate && ev_hit(int'(sel[n*SEL_W +: SEL_W]), evt)) begin
               if (exp_cnt[n] == MAXV) exp_ovf[n] = 1'b1;
               else exp_cnt[n] = exp_cnt[n] + 1;
            end
         end
         if (!is_paired(mode)) exp_open = 1'b0;
         else if (!exp_open && st) exp_open = 1'b1;
         else if (exp_open && sp) exp_open = 1'b0;
      end
   endtask

   task automatic tick(input int k = 1);
      for (int i = 0; i < k; i++) begin
         @(posedge clk);
         if (rst_n) model_edge();
         #1;
      end
   endtask

   task automatic set_sel(input int n, input int code);
      sel[n*SEL_W +: SEL_W] = SEL_W'(code);
   endtask

   // all counters read back through the port, between edges
   task automatic check_all(input string tag);
      int ev;
      for (int n = 0; n < NUM_CTR; n++) begin
         rd_idx = IDX_W'(n);
         #0.4;
         ev = exp_ovf[n] ? MAXV : exp_cnt[n];
         n_tests++;
         if (rd_data !== CNT_W'(ev) || rd_ovf !== exp_ovf[n]) begin
            n_fail++;
            $display("FAIL %s ctr%0d: got data=%0d ovf=%0b, expected data=%0d ovf=%0b",
                     tag, n, rd_data, rd_ovf, ev, exp_ovf[n]);
         end
      end
   endtask

   task automatic pulse(input bit c1, input bit c2);
      ch1 = c1; ch2 = c2;
      tick(1);
      ch1 = 1'b0; ch2 = 1'b0;
   endtask

   initial begin
      for (int n = 0; n < NUM_CTR; n++) begin exp_cnt[n] = 0; exp_ovf[n] = 1'b0; end
      void'($urandom(32'd1234));
      #12 rst_n = 1'b1;
      tick(1);
      check_all("R1 reset");

      // whole-run: cycles, branch strobe, off, out-of-range code
      mode = 2'd0;
      set_sel(0, 1); set_sel(1, 2); set_sel(2, 0); set_sel(3, 12);
      run = 1'b1;
      for (int i = 0; i < 40; i++) begin evt = NUM_EVT'($urandom); tick(1); end
      check_all("R2/R7/R8 whole-run");
      run = 1'b0;
      for (int i = 0; i < 20; i++) begin evt = NUM_EVT'($urandom); tick(1); end
      check_all("R2 break holds");

      // reserved mode 3 counts like whole-run
      mode = 2'd3; run = 1'b1;
      set_sel(2, 9); set_sel(3, 5);
      for (int i = 0; i < 25; i++) begin evt = NUM_EVT'($urandom); tick(1); end
      check_all("R2/R7 reserved mode");

      // paired ch2 -> ch1
      clr = 1'b1; tick(1); clr = 1'b0;
      check_all("R10 clear");
      mode = 2'd1; evt = '0;
      set_sel(0, 1); set_sel(1, 1); set_sel(2, 3); set_sel(3, 1);
      tick(3);
      check_all("R3 closed window");
      pulse(1'b0, 1'b1);          // open: counting from next edge
      tick(5);
      pulse(1'b1, 1'b0);          // closing cycle still counted
      tick(4);
      check_all("R3 window span");
      pulse(1'b0, 1'b1);
      tick(3);
      pulse(1'b1, 1'b0);
      check_all("R5 reopen accumulates");
      pulse(1'b0, 1'b1);
      run = 1'b0; tick(4); run = 1'b1;
      tick(2);
      pulse(1'b1, 1'b0);
      check_all("R5 run gating inside window");
      pulse(1'b1, 1'b1);          // closed: end ignored, opens
      tick(3);
      pulse(1'b0, 1'b1);          // open: start has no effect
      tick(2);
      pulse(1'b1, 1'b1);          // open: closes
      tick(3);
      check_all("R6 simultaneous start/end");

      // swapped pairing
      mode = 2'd2;
      pulse(1'b0, 1'b1);          // ch2 is an end event here: no open
      tick(3);
      pulse(1'b1, 1'b0);
      tick(6);
      pulse(1'b0, 1'b1);
      tick(3);
      check_all("R4 swapped pairing");

      // overflow of a cycle counter
      mode = 2'd0; set_sel(1, 0); set_sel(2, 0); set_sel(3, 2);
      clr = 1'b1; tick(1); clr = 1'b0;
      tick(MAXV);
      check_all("R9 at max");
      tick(1);
      check_all("R9 overflow set");
      tick(30);
      check_all("R9 overflow sticky");
      clr = 1'b1; evt = '1; tick(1); clr = 1'b0;
      check_all("R10 clear beats events");
      rd_idx = 2'd3; #0.3;
      n_tests++;
      if (rd_ovf !== 1'b0) begin
         n_fail++;
         $display("FAIL R11 read port: got ovf=%0b, expected 0", rd_ovf);
      end

      // seeded random mix
      for (int blk = 0; blk < 60; blk++) begin
         mode = 2'($urandom_range(0, 3));
         for (int n = 0; n < NUM_CTR; n++) set_sel(n, $urandom_range(0, 11));
         for (int i = 0; i < 50; i++) begin
            evt = NUM_EVT'($urandom);
            run = ($urandom_range(0, 9) != 0);
            ch1 = ($urandom_range(0, 7) == 0);
            ch2 = ($urandom_range(0, 7) == 0);
            clr = ($urandom_range(0, 199) == 0);
            tick(1);
         end
         ch1 = 1'b0; ch2 = 1'b0; clr = 1'b0;
         check_all("R2-R8 random mix");
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule